// File: doc/BRIEF.md
# Playback Sample FIFO with DMA Request

This block buffers audio samples between a loader and a playback engine. Samples come in either from a host bus write strobe or from a DMA write strobe, and the engine drains them one entry per sample tick. The storage is a fixed pool of bits. A configuration input splits it into byte-wide entries or word-wide entries, and a depth code picks the full pool, half of it, a quarter of it, or a single-entry pass-through slot.

The FIFO drives three level flags: empty, more-than-half and full. Each flag can be inverted. When DMA loading is enabled, a request output asks for data. The request rises on a play command and stays high until the FIFO fills. It then stays low until the fill level falls back to half, which gives it hysteresis. A DMA write counts only while the acknowledge input is at its selected active level.

Playback starts on the first write accepted after a play command, and a one-cycle start pulse marks it. Playback ends on a stop command, or when the FIFO has stayed empty with no write for a fixed number of cycles. A write that arrives while the FIFO is full is dropped and sets a sticky status bit. A stop command clears this bit, empties the FIFO and clears all flags.

Top module: `pbk_fifo`

## Requirements
- R1: After reset the empty flag is active, the half and full flags and the DMA request are inactive, `playing`, `start_pulse`, `wr_at_full` and `rd_underrun` are 0, and `rd_data` is 0.
- R2: Capacity in entries is 128>>`cfg_depth` with byte entries (`cfg_wide`=0) and 64>>`cfg_depth` with word entries (`cfg_wide`=1), for `cfg_depth` 0, 1 and 2. Code 3 gives exactly one entry. With the default polarity, empty is high when no entry is stored, half is high when the count exceeds capacity/2, and full is high when the count equals capacity. Each flag changes at the clock edge of the write or pop that moves the count.
- R3: A write while full is dropped and the stored contents are left as they were.
- R4: A write while full sets `wr_at_full`. The bit stays set until a stop command clears it.
- R5: With `cfg_flag_low`=1, all three level flags are driven inverted.
- R6: With `cfg_dma_en`=1, a play command in the idle state raises the request at that edge. The request drops at the edge where the count reaches capacity. It rises again at the edge where the count falls to capacity/2 or below. `cfg_req_low`=1 inverts the request pin.
- R7: A `dma_iow` strobe writes only when `cfg_dma_en`=1 and `dma_ack` is at its active level. `cfg_ack_high`=1 makes acknowledge active high; otherwise it is active low.
- R8: The first write accepted after a play command sets `playing` and pulses `start_pulse` for exactly one cycle, both at that write's edge.
- R9: A stop command empties the FIFO and clears `wr_at_full`, `playing` and the DMA request at its edge. A write in the same cycle is discarded.
- R10: While playing, after IDLE_TMO consecutive edges with the FIFO empty and no write, `playing` falls and the request clears.
- R11: `rd_tick` pops the oldest entry into `rd_data` at that edge, in write order. Byte entries appear in the low byte with the upper byte 0. Word entries appear as the full word.
- R12: `rd_tick` on an empty FIFO leaves `rd_data` unchanged and pulses `rd_underrun` for one cycle.
- R13: A write and a pop in the same cycle on a FIFO that is neither empty nor full leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wide | input | 1 | 1: word entries, 0: byte entries |
| cfg_depth | input | 2 | 0 full pool, 1 half, 2 quarter, 3 single entry |
| cfg_flag_low | input | 1 | Invert the empty, half and full flags |
| cfg_req_low | input | 1 | Invert the DMA request |
| cfg_ack_high | input | 1 | Acknowledge active high when 1 |
| cfg_dma_en | input | 1 | Enable DMA loading and request |
| play | input | 1 | Play command pulse |
| stop | input | 1 | Stop command pulse |
| host_wr | input | 1 | Host write strobe |
| wr_data | input | WORD_W | Write data shared by host and DMA |
| dma_iow | input | 1 | DMA write strobe |
| dma_ack | input | 1 | DMA acknowledge |
| rd_tick | input | 1 | Sample-tick pop request |
| rd_data | output | WORD_W | Last popped entry |
| rd_underrun | output | 1 | Pop attempted on empty FIFO |
| flag_empty | output | 1 | Empty flag |
| flag_half | output | 1 | More-than-half flag |
| flag_full | output | 1 | Full flag |
| dma_req | output | 1 | DMA request |
| wr_at_full | output | 1 | Sticky: write arrived while full |
| start_pulse | output | 1 | One-cycle playback start |
| playing | output | 1 | Playback in progress |

## Verification
Flags, `wr_at_full`, `playing`, `start_pulse` and the DMA request are all due at the same edge that samples the triggering command or strobe. They come from one register stage with no extra latency. `rd_data` and `rd_underrun` are due at the edge that samples `rd_tick`. The timeout falls exactly IDLE_TMO edges after the pop that empties the FIFO. The bench drives every stimulus at a falling edge, lets exactly one rising edge pass, and samples at the next falling edge. For the hysteresis and timeout windows it checks the cycle just before the expected change as well as the cycle of the change.

// File: rtl/pbk_fifo_pkg.sv
package pbk_fifo_pkg;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_ARMED = 2'd1,
      PS_RUN   = 2'd2
   } play_st_e;

   typedef enum logic [1:0] {
      SZ_FULL    = 2'd0,
      SZ_HALF    = 2'd1,
      SZ_QUARTER = 2'd2,
      SZ_BYPASS  = 2'd3
   } depth_sel_e;

endpackage

// File: rtl/pbk_fifo_level.sv
// Occupancy counter, capacity decode and raw (active-high) level flags.
module pbk_fifo_level
   import pbk_fifo_pkg::*;
#(
   parameter int SLOTS  = 128,
   parameter int LSEL_W = 1,
   parameter int CNT_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wide,
   input  logic [1:0]       depth_sel,
   input  logic             wr_req,
   input  logic             rd_req,
   output logic             push,
   output logic             pop,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [CNT_W-1:0] cap,
   output logic [CNT_W-1:0] half_lvl,
   output logic             empty,
   output logic             half,
   output logic             full
);

   always_comb begin
      if (depth_sel == SZ_BYPASS) begin
         cap = CNT_W'(1);
      end else begin
         cap = (CNT_W'(SLOTS) >> (wide ? LSEL_W : 0)) >> depth_sel;
      end
   end

   assign half_lvl = cap >> 1;
   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == cap);
   assign half     = (cnt_q > half_lvl);

   assign push = wr_req & ~full;
   assign pop  = rd_req & ~empty;

   always_comb begin
      if (clr) begin
         cnt_nxt = '0;
      end else begin
         cnt_nxt = cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
      end
   end

endmodule

// File: rtl/pbk_fifo_store.sv
// Lane-organised storage pool with circular pointers that wrap at the
// selected capacity.
module pbk_fifo_store #(
   parameter int SLOTS  = 128,
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   parameter int CNT_W  = 8,
   parameter int PTR_W  = 7,
   parameter int LSEL_W = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wide,
   input  logic [CNT_W-1:0]        cap,
   input  logic                    push,
   input  logic                    pop,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic [LANES*LANE_W-1:0] rd_data
);

   logic [LANE_W-1:0] mem [SLOTS];
   logic [PTR_W-1:0]  wp_q, rp_q, last_ptr;
   logic [PTR_W-1:0]  widx [LANES];
   logic [PTR_W-1:0]  ridx [LANES];

   assign last_ptr = PTR_W'(cap - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else if (clr) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= (wp_q == last_ptr) ? '0 : wp_q + PTR_W'(1);
         if (pop)  rp_q <= (rp_q == last_ptr) ? '0 : rp_q + PTR_W'(1);
      end
   end

   generate
      if (LANES == 1) begin : g_single_lane
         assign widx[0] = wp_q;
         assign ridx[0] = rp_q;
      end else begin : g_multi_lane
         for (genvar g = 0; g < LANES; g++) begin : g_idx
            assign widx[g] = wide ? {wp_q[PTR_W-LSEL_W-1:0], LSEL_W'(g)} : wp_q;
            assign ridx[g] = wide ? {rp_q[PTR_W-LSEL_W-1:0], LSEL_W'(g)} : rp_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) begin
         for (int l = 0; l < LANES; l++) begin
            if (wide || l == 0) mem[widx[l]] <= wr_data[l*LANE_W +: LANE_W];
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data[g*LANE_W +: LANE_W] <= '0;
         end else if (pop) begin
            if (g == 0 || wide) rd_data[g*LANE_W +: LANE_W] <= mem[ridx[g]];
            else                rd_data[g*LANE_W +: LANE_W] <= '0;
         end
      end
   end

endmodule

// File: rtl/pbk_fifo_ctrl.sv
// Playback state, start pulse, idle timeout and DMA request hysteresis.
module pbk_fifo_ctrl
   import pbk_fifo_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int TMO   = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             play,
   input  logic             stop,
   input  logic             dma_en,
   input  logic             push,
   input  logic             empty,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] cap,
   input  logic [CNT_W-1:0] half_lvl,
   output play_st_e         st_q,
   output logic             start_q,
   output logic             req_q
);

   localparam int TW = $clog2(TMO + 1);

   logic [TW-1:0] idle_q;
   logic          starve, tmo_hit;

   assign starve  = (st_q == PS_RUN) && empty && !push;
   assign tmo_hit = starve && (idle_q == TW'(TMO - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_IDLE;
         start_q <= 1'b0;
         idle_q  <= '0;
      end else if (stop) begin
         st_q    <= PS_IDLE;
         start_q <= 1'b0;
         idle_q  <= '0;
      end else begin
         start_q <= 1'b0;
         unique case (st_q)
            PS_IDLE:  if (play) st_q <= PS_ARMED;
            PS_ARMED: if (push) begin
               st_q    <= PS_RUN;
               start_q <= 1'b1;
            end
            PS_RUN: begin
               if (tmo_hit) begin
                  st_q   <= PS_IDLE;
                  idle_q <= '0;
               end else if (starve) begin
                  idle_q <= idle_q + TW'(1);
               end else begin
                  idle_q <= '0;
               end
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (stop || tmo_hit || !dma_en) begin
         req_q <= 1'b0;
      end else if (req_q) begin
         if (cnt_nxt == cap) req_q <= 1'b0;
      end else if ((play && st_q == PS_IDLE) ||
                   (st_q != PS_IDLE && cnt_nxt <= half_lvl)) begin
         req_q <= 1'b1;
      end
   end

endmodule

// File: rtl/pbk_fifo.sv
module pbk_fifo
   import pbk_fifo_pkg::*;
#(
   parameter int STORE_BITS = 1024,
   parameter int WORD_W     = 16,
   parameter int LANE_W     = 8,
   parameter int IDLE_TMO   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic [1:0]        cfg_depth,
   input  logic              cfg_flag_low,
   input  logic              cfg_req_low,
   input  logic              cfg_ack_high,
   input  logic              cfg_dma_en,
   input  logic              play,
   input  logic              stop,
   input  logic              host_wr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              dma_iow,
   input  logic              dma_ack,
   input  logic              rd_tick,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_underrun,
   output logic              flag_empty,
   output logic              flag_half,
   output logic              flag_full,
   output logic              dma_req,
   output logic              wr_at_full,
   output logic              start_pulse,
   output logic              playing
);

   localparam int SLOTS  = STORE_BITS / LANE_W;
   localparam int LANES  = WORD_W / LANE_W;
   localparam int LSEL_W = $clog2(LANES);
   localparam int CNT_W  = $clog2(SLOTS + 1);
   localparam int PTR_W  = $clog2(SLOTS);

   if (LANES * LANE_W != WORD_W)       begin : g_bad_word  $error("WORD_W must be a multiple of LANE_W"); end
   if (SLOTS * LANE_W != STORE_BITS)   begin : g_bad_pool  $error("STORE_BITS must be a multiple of LANE_W"); end
   if ((1 << PTR_W) != SLOTS)          begin : g_bad_pow2  $error("slot count must be a power of two"); end
   if ((1 << LSEL_W) != LANES)         begin : g_bad_lanes $error("lane count must be a power of two"); end
   if (((SLOTS >> LSEL_W) >> 2) < 2)   begin : g_bad_small $error("smallest depth must hold two entries"); end
   if (IDLE_TMO < 2)                   begin : g_bad_tmo   $error("IDLE_TMO must be at least 2"); end

   logic             ack_on, wr_evt;
   logic             push, pop;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, cap, half_lvl;
   logic             lv_empty, lv_half, lv_full;
   play_st_e         st_q;
   logic             req_q;
   logic             wat_q, udr_q;

   assign ack_on = cfg_ack_high ? dma_ack : ~dma_ack;
   assign wr_evt = host_wr | (cfg_dma_en & dma_iow & ack_on);

   pbk_fifo_level #(
      .SLOTS (SLOTS),
      .LSEL_W(LSEL_W),
      .CNT_W (CNT_W)
   ) i_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (stop),
      .wide     (cfg_wide),
      .depth_sel(cfg_depth),
      .wr_req   (wr_evt),
      .rd_req   (rd_tick),
      .push     (push),
      .pop      (pop),
      .cnt_q    (cnt_q),
      .cnt_nxt  (cnt_nxt),
      .cap      (cap),
      .half_lvl (half_lvl),
      .empty    (lv_empty),
      .half     (lv_half),
      .full     (lv_full)
   );

   pbk_fifo_store #(
      .SLOTS (SLOTS),
      .LANE_W(LANE_W),
      .LANES (LANES),
      .CNT_W (CNT_W),
      .PTR_W (PTR_W),
      .LSEL_W(LSEL_W)
   ) i_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (stop),
      .wide   (cfg_wide),
      .cap    (cap),
      .push   (push & ~stop),
      .pop    (pop & ~stop),
      .wr_data(wr_data),
      .rd_data(rd_data)
   );

   pbk_fifo_ctrl #(
      .CNT_W(CNT_W),
      .TMO  (IDLE_TMO)
   ) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .play    (play),
      .stop    (stop),
      .dma_en  (cfg_dma_en),
      .push    (push),
      .empty   (lv_empty),
      .cnt_nxt (cnt_nxt),
      .cap     (cap),
      .half_lvl(half_lvl),
      .st_q    (st_q),
      .start_q (start_pulse),
      .req_q   (req_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wat_q <= 1'b0;
         udr_q <= 1'b0;
      end else if (stop) begin
         wat_q <= 1'b0;
         udr_q <= 1'b0;
      end else begin
         if (wr_evt && lv_full) wat_q <= 1'b1;
         udr_q <= rd_tick & lv_empty;
      end
   end

   assign wr_at_full  = wat_q;
   assign rd_underrun = udr_q;
   assign flag_empty  = lv_empty ^ cfg_flag_low;
   assign flag_half   = lv_half  ^ cfg_flag_low;
   assign flag_full   = lv_full  ^ cfg_flag_low;
   assign dma_req     = req_q    ^ cfg_req_low;
   assign playing     = (st_q == PS_RUN);

endmodule

// File: rtl/pbk_fifo_chk.sv
module pbk_fifo_chk #(
   parameter int CNT_W  = 8,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop,
   input logic              wr_evt,
   input logic              push,
   input logic              pop,
   input logic              lv_empty,
   input logic              lv_full,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [WORD_W-1:0] rd_data,
   input logic              rd_underrun,
   input logic              wr_at_full,
   input logic              start_pulse,
   input logic              playing
);

   // R2
   a_r2_empty_full_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(lv_empty && lv_full));

   // R3
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_full && !pop && !stop) |=> lv_full);

   // R4
   a_r4_sticky_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_at_full) |-> $past(wr_evt && lv_full));

   // R8
   a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (playing && $rose(playing)));

   // R9
   a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (cnt_q == '0 && !wr_at_full && !playing));

   // R12
   a_r12_underrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
      rd_underrun |-> $stable(rd_data));

   // R13
   a_r13_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !stop) |=> $stable(cnt_q));

endmodule

bind pbk_fifo pbk_fifo_chk #(
   .CNT_W (CNT_W),
   .WORD_W(WORD_W)
) i_pbk_fifo_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop       (stop),
   .wr_evt     (wr_evt),
   .push       (push),
   .pop        (pop),
   .lv_empty   (lv_empty),
   .lv_full    (lv_full),
   .cnt_q      (cnt_q),
   .rd_data    (rd_data),
   .rd_underrun(rd_underrun),
   .wr_at_full (wr_at_full),
   .start_pulse(start_pulse),
   .playing    (playing)
);

// File: tb/test_pbk_fifo.sv
`timescale 1ns/1ps
module test_pbk_fifo;

   localparam int TMO = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wide = 1'b0;
   logic [1:0]  cfg_depth = 2'd0;
   logic        cfg_flag_low = 1'b0;
   logic        cfg_req_low = 1'b0;
   logic        cfg_ack_high = 1'b0;
   logic        cfg_dma_en = 1'b0;
   logic        play = 1'b0;
   logic        stop = 1'b0;
   logic        host_wr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        dma_iow = 1'b0;
   logic        dma_ack = 1'b1;
   logic        rd_tick = 1'b0;
   logic [15:0] rd_data;
   logic        rd_underrun, flag_empty, flag_half, flag_full;
   logic        dma_req, wr_at_full, start_pulse, playing;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pbk_fifo #(.IDLE_TMO(TMO)) i_pbk_fifo (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_depth(cfg_depth),
      .cfg_flag_low(cfg_flag_low), .cfg_req_low(cfg_req_low),
      .cfg_ack_high(cfg_ack_high), .cfg_dma_en(cfg_dma_en),
      .play(play), .stop(stop), .host_wr(host_wr), .wr_data(wr_data),
      .dma_iow(dma_iow), .dma_ack(dma_ack), .rd_tick(rd_tick),
      .rd_data(rd_data), .rd_underrun(rd_underrun), .flag_empty(flag_empty),
      .flag_half(flag_half), .flag_full(flag_full), .dma_req(dma_req),
      .wr_at_full(wr_at_full), .start_pulse(start_pulse), .playing(playing)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] d);
      host_wr = 1'b1; wr_data = d; step(); host_wr = 1'b0;
   endtask

   task automatic rd();
      rd_tick = 1'b1; step(); rd_tick = 1'b0;
   endtask

   task automatic do_play();
      play = 1'b1; step(); play = 1'b0;
   endtask

   task automatic do_stop();
      stop = 1'b1; step(); stop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "empty",   flag_empty, 1);
      chk("R1", "half",    flag_half, 0);
      chk("R1", "full",    flag_full, 0);
      chk("R1", "req",     dma_req, 0);
      chk("R1", "playing", playing, 0);
      chk("R1", "start",   start_pulse, 0);
      chk("R1", "sticky",  wr_at_full, 0);
      chk("R1", "underrun", rd_underrun, 0);
      chk("R1", "rd_data", rd_data, 0);
   endtask

   task automatic t_byte_fill();
      cfg_wide = 1'b0; cfg_depth = 2'd2;     // 32 byte entries, half = 16
      for (int i = 0; i < 16; i++) wr({8'hEE, 8'(i + 1)});
      chk("R2", "half at 16/32", flag_half, 0);
      wr({8'hEE, 8'd17});
      chk("R2", "half at 17/32", flag_half, 1);
      for (int i = 17; i < 31; i++) wr({8'hEE, 8'(i + 1)});
      chk("R2", "full at 31/32", flag_full, 0);
      wr({8'hEE, 8'd32});
      chk("R2", "full at 32/32", flag_full, 1);
      chk("R4", "sticky before", wr_at_full, 0);
      wr(16'h00AA);
      chk("R4", "sticky set", wr_at_full, 1);
      chk("R3", "still full", flag_full, 1);
      for (int i = 0; i < 32; i++) begin
         rd();
         chk("R11", "byte order", rd_data, 32'(i + 1));
      end
      chk("R3", "empty after 32 pops", flag_empty, 1);
      rd();
      chk("R12", "underrun pulse", rd_underrun, 1);
      chk("R12", "data held", rd_data, 32);
      step();
      chk("R12", "underrun one cycle", rd_underrun, 0);
      chk("R4", "sticky kept", wr_at_full, 1);
      do_stop();
      chk("R9", "sticky cleared", wr_at_full, 0);
   endtask

   task automatic t_word_play();
      cfg_wide = 1'b1; cfg_depth = 2'd2;     // 16 word entries, half = 8
      do_play();
      chk("R8", "not playing before write", playing, 0);
      wr(16'h1234);
      chk("R8", "start pulse", start_pulse, 1);
      chk("R8", "playing", playing, 1);
      step();
      chk("R8", "start pulse ends", start_pulse, 0);
      for (int i = 1; i < 16; i++) wr(16'h1000 + 16'(i));
      chk("R2", "word full at 16", flag_full, 1);
      rd();
      chk("R11", "word data", rd_data, 16'h1234);
      chk("R2", "not full after pop", flag_full, 0);
      do_stop();
      chk("R9", "empty", flag_empty, 1);
      chk("R9", "not playing", playing, 0);
   endtask

   task automatic t_polarity();
      cfg_wide = 1'b0; cfg_depth = 2'd0;
      cfg_flag_low = 1'b1;
      step();
      chk("R5", "empty inverted", flag_empty, 0);
      chk("R5", "half inverted", flag_half, 1);
      chk("R5", "full inverted", flag_full, 1);
      wr(16'h0001);
      chk("R5", "non-empty inverted", flag_empty, 1);
      do_stop();
      cfg_flag_low = 1'b0;
   endtask

   task automatic t_dma();
      cfg_wide = 1'b1; cfg_depth = 2'd1;     // 32 word entries, half = 16
      dma_iow = 1'b1; dma_ack = 1'b0; step(); dma_iow = 1'b0;
      chk("R7", "iow ignored when dma off", flag_empty, 1);
      cfg_dma_en = 1'b1; cfg_ack_high = 1'b0;
      do_play();
      chk("R6", "req at play", dma_req, 1);
      dma_ack = 1'b1; dma_iow = 1'b1; step(); dma_iow = 1'b0;
      chk("R7", "inactive ack ignored", flag_empty, 1);
      dma_ack = 1'b0;
      for (int i = 0; i < 31; i++) begin
         dma_iow = 1'b1; wr_data = 16'h2000 + 16'(i); step(); dma_iow = 1'b0;
      end
      chk("R7", "dma writes accepted", playing, 1);
      chk("R6", "req held at 31", dma_req, 1);
      dma_iow = 1'b1; wr_data = 16'h201F; step(); dma_iow = 1'b0;
      chk("R6", "req drops at full", dma_req, 0);
      for (int i = 0; i < 15; i++) rd();
      chk("R6", "req low at 17", dma_req, 0);
      rd();
      chk("R6", "req back at 16", dma_req, 1);
      cfg_req_low = 1'b1; step();
      chk("R6", "req inverted", dma_req, 0);
      cfg_ack_high = 1'b1; dma_ack = 1'b0;
      dma_iow = 1'b1; wr_data = 16'hBEEF; step(); dma_iow = 1'b0;
      chk("R7", "high-active ack, low ignored", flag_half, 0);
      dma_ack = 1'b1;
      dma_iow = 1'b1; step(); dma_iow = 1'b0;
      chk("R7", "high-active ack accepted", flag_half, 1);
      do_stop();
      chk("R9", "req cleared", dma_req, 1);
      cfg_req_low = 1'b0; cfg_ack_high = 1'b0; cfg_dma_en = 1'b0; dma_ack = 1'b1;
      step();
      chk("R9", "req low", dma_req, 0);
   endtask

   task automatic t_timeout();
      cfg_wide = 1'b0; cfg_depth = 2'd0;
      do_play();
      wr(16'h0042);
      rd();
      for (int i = 0; i < TMO - 1; i++) step();
      chk("R10", "still playing", playing, 1);
      step();
      chk("R10", "timeout ends play", playing, 0);
   endtask

   task automatic t_push_pop();
      do_stop();
      wr(16'h00A1);
      host_wr = 1'b1; wr_data = 16'h00B2; rd_tick = 1'b1; step();
      host_wr = 1'b0; rd_tick = 1'b0;
      chk("R13", "pop data", rd_data, 16'h00A1);
      chk("R13", "count kept", flag_empty, 0);
      rd();
      chk("R13", "second entry", rd_data, 16'h00B2);
      chk("R13", "empty after", flag_empty, 1);
   endtask

   task automatic t_bypass();
      cfg_wide = 1'b0; cfg_depth = 2'd3;
      wr(16'h0055);
      chk("R2", "single entry full", flag_full, 1);
      chk("R2", "single entry half", flag_half, 1);
      wr(16'h0066);
      chk("R4", "sticky single", wr_at_full, 1);
      rd();
      chk("R3", "kept first", rd_data, 16'h0055);
      chk("R2", "single empty", flag_empty, 1);
      host_wr = 1'b1; wr_data = 16'h0077; stop = 1'b1; step();
      host_wr = 1'b0; stop = 1'b0;
      chk("R9", "write with stop dropped", flag_empty, 1);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_byte_fill();
      t_word_play();
      t_polarity();
      t_dma();
      t_timeout();
      t_push_pop();
      t_bypass();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule